// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between an on-chip requester and an asynchronous extended-data-out DRAM organised as 4M words of 4 bits. Requests arrive on a valid/ready port that carries a 22-bit word address, a direction bit and 4 bits of write data. The controller divides the address into a 12-bit row (upper bits) and a 10-bit column (lower bits). It time-multiplexes the two onto one 12-bit address bus and produces the active-low row strobe, column strobe, write enable and output enable.

After an access the row stays open. A later request to the same row is served by strobing only the column. A request to another row closes the page, waits out the precharge and activates the new row. Read data is sampled one cycle after the column strobe has returned high, using the interval in which an EDO part keeps its outputs driven. Each completed access produces a one-cycle response strobe, and read data travels with that strobe. A free-running timer asks for a CAS-before-RAS refresh once per interval. The request takes priority over new accesses at the next access boundary and closes any open page first.

All strobe timings are parameters counted in clock cycles.

Top module: `edo_page_ctrl`

## Requirements
- R1: The row address is `req_addr[21:10]`, driven on `dram_addr` in the cycle where `dram_ras_n` falls. The column is `req_addr[9:0]`, driven on `dram_addr[9:0]` with `dram_addr[11:10]` zero in the cycle where `dram_cas_n` falls.
- R2: A request whose row equals the open row is accepted while `dram_ras_n` stays low, without a new row activation.
- R3: A request to a different row, or a refresh, raises `dram_ras_n`. Before any later falling edge of `dram_ras_n`, the strobe stays high for at least T_RP cycles.
- R4: On a row activation, the column strobe falls exactly T_RCD cycles after the row strobe falls.
- R5: `dram_cas_n` stays low for at least T_CAS cycles. Between two column strobes of one open page it stays high for at least T_CP cycles. `dram_ras_n` stays low for at least T_RAS cycles.
- R6: Every accepted request yields exactly one one-cycle `rsp_valid` pulse, in request order. For reads, `rsp_rdata` holds the word the DRAM drove after `dram_cas_n` had risen.
- R7: For a write, `dram_we_n` is low and `dram_dq_oe` is high in the cycle where `dram_cas_n` falls, so the word on `dram_dq_out` is stored at the addressed location.
- R8: A refresh is a cycle where `dram_cas_n` falls while `dram_ras_n` is high. The column strobe then stays low for at least T_CSR cycles before `dram_ras_n` falls. At least one refresh occurs per REF_INTERVAL cycles on average.
- R9: A pending refresh is served at the next access boundary. The gap between consecutive refreshes, or from reset to the first refresh, never exceeds REF_INTERVAL plus 32 cycles. No refresh request is lost.
- R10: During and directly after reset, all four strobes are high, `dram_dq_oe` is low and `rsp_valid` is low.
- R11: `dram_oe_n` is never low while `dram_we_n` is low or while `dram_dq_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in upper 12 bits |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 4 | Read data, valid with rsp_valid |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Controller drives the data bus |
| dram_dq_in | input | 4 | Data from the DRAM |

## Verification
The hardest situation to reach is a refresh request that matures while a long run of same-row hits keeps the page open. The controller must then refuse the next hit, wait out the minimum row-strobe time, refresh, and reopen the row without losing or reordering a response. The stimulus produces this with a stream of several hundred back-to-back hits to one row that lasts longer than a refresh interval. The bench then checks that refreshes occurred inside the stream and that the number of extra activations does not exceed the number of refreshes. A DRAM model in the bench makes read data valid only from the second cycle of the column strobe until output enable rises, so a capture made at the wrong moment returns corrupted data.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_PRE  = 4'd1,
    ST_ACT  = 4'd2,
    ST_CSET = 4'd3,
    ST_COL  = 4'd4,
    ST_CAP  = 4'd5,
    ST_OPEN = 4'd6,
    ST_RCSR = 4'd7,
    ST_RRAS = 4'd8
  } edo_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned bits_for(int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
  parameter int unsigned REF_INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_pend,
  output logic ref_tick
);
  import edo_pkg::*;

  localparam int unsigned TW = bits_for(REF_INTERVAL);
  localparam logic [TW-1:0] RELOAD = TW'(REF_INTERVAL - 1);

  logic [TW-1:0] tmr;

  assign ref_tick = (tmr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr      <= RELOAD;
      ref_pend <= 1'b0;
    end else begin
      tmr <= ref_tick ? RELOAD : tmr - 1'b1;
      if (ref_tick)     ref_pend <= 1'b1;
      else if (ref_ack) ref_pend <= 1'b0;
    end
  end

  // R9: a new tick never finds the previous request still waiting
  p_ref_not_lost_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |-> !ref_pend);

endmodule

// File: rtl/edo_seq.sv
module edo_seq #(
  parameter int unsigned ROW_W = 12,
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_CAS = 2,
  parameter int unsigned T_CP  = 1,
  parameter int unsigned T_RP  = 4,
  parameter int unsigned T_RAS = 6,
  parameter int unsigned T_CSR = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [ROW_W-1:0] req_row,
  input  logic             ref_pend,
  output logic             req_ready,
  output logic             accept,
  output logic             ref_ack,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             bus_col,
  output logic             drive_dq,
  output logic             cap_now
);
  import edo_pkg::*;

  localparam int unsigned MAXT = max2(max2(max2(T_RCD, T_CAS), max2(T_CP, T_RP)),
                                      max2(T_RAS, T_CSR));
  localparam int unsigned CW = bits_for(MAXT);
  localparam int unsigned LW = bits_for(T_RAS);
  localparam int unsigned HW = bits_for(T_RP);
  localparam logic [LW-1:0] RAS_MAX = LW'(T_RAS);
  localparam logic [LW-1:0] RAS_M1  = LW'(T_RAS - 1);
  localparam logic [HW-1:0] RP_MAX  = HW'(T_RP);

  edo_state_e       state, nxt_state;
  logic [CW-1:0]    cnt, nxt_cnt;
  logic [ROW_W-1:0] open_row;
  logic             op_we;
  logic [LW-1:0]    ras_lo_cnt;
  logic [HW-1:0]    ras_hi_cnt;

  // named events for checking
  logic page_hit, hit_accept, close_page, ras_ok, cnt_zero;

  assign cnt_zero   = (cnt == '0);
  assign page_hit   = (state == ST_OPEN) && (req_row == open_row);
  assign ras_ok     = (ras_lo_cnt >= RAS_M1);
  assign req_ready  = !ref_pend && ((state == ST_IDLE) || page_hit);
  assign accept     = req_valid && req_ready;
  assign hit_accept = accept && (state == ST_OPEN);
  assign close_page = (state == ST_OPEN) && !hit_accept && ras_ok &&
                      (ref_pend || (req_valid && !page_hit));
  assign ref_ack    = (state == ST_IDLE) && ref_pend;

  always_comb begin
    nxt_state = state;
    nxt_cnt   = cnt_zero ? cnt : cnt - 1'b1;
    unique case (state)
      ST_IDLE: begin
        if (ref_pend) begin
          nxt_state = ST_RCSR;
          nxt_cnt   = CW'(T_CSR - 1);
        end else if (req_valid) begin
          nxt_state = ST_ACT;
          nxt_cnt   = CW'(T_RCD - 2);
        end
      end
      ST_ACT:  if (cnt_zero) nxt_state = ST_CSET;
      ST_CSET: begin
        nxt_state = ST_COL;
        nxt_cnt   = CW'(T_CAS - 1);
      end
      ST_COL: if (cnt_zero) begin
        nxt_state = ST_CAP;
        nxt_cnt   = CW'(T_CP - 1);
      end
      ST_CAP:  if (cnt_zero) nxt_state = ST_OPEN;
      ST_OPEN: begin
        if (hit_accept) begin
          nxt_state = ST_CSET;
        end else if (close_page) begin
          nxt_state = ST_PRE;
          nxt_cnt   = CW'(T_RP - 1);
        end
      end
      ST_PRE:  if (cnt_zero) nxt_state = ST_IDLE;
      ST_RCSR: if (cnt_zero) begin
        nxt_state = ST_RRAS;
        nxt_cnt   = CW'(T_RAS - 1);
      end
      ST_RRAS: if (cnt_zero) begin
        nxt_state = ST_PRE;
        nxt_cnt   = CW'(T_RP - 1);
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      open_row <= '0;
      op_we    <= 1'b0;
    end else begin
      state <= nxt_state;
      cnt   <= nxt_cnt;
      if (accept) begin
        op_we    <= req_we;
        open_row <= req_row;
      end
    end
  end

  // strobe decode
  always_comb begin
    ras_n    = !(state inside {ST_ACT, ST_CSET, ST_COL, ST_CAP, ST_OPEN, ST_RRAS});
    cas_n    = !(state inside {ST_COL, ST_RCSR, ST_RRAS});
    drive_dq = op_we && (state inside {ST_CSET, ST_COL});
    we_n     = !drive_dq;
    oe_n     = !(!op_we && (state inside {ST_COL, ST_CAP}));
    bus_col  = state inside {ST_CSET, ST_COL, ST_CAP, ST_OPEN};
    cap_now  = (state == ST_CAP) && (cnt == CW'(T_CP - 1));
  end

  // row-strobe low / high duration trackers, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_lo_cnt <= '0;
      ras_hi_cnt <= RP_MAX;
    end else if (!ras_n) begin
      ras_hi_cnt <= '0;
      if (ras_lo_cnt != RAS_MAX) ras_lo_cnt <= ras_lo_cnt + 1'b1;
    end else begin
      ras_lo_cnt <= '0;
      if (ras_hi_cnt != RP_MAX) ras_hi_cnt <= ras_hi_cnt + 1'b1;
    end
  end

  p_precharge_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (ras_hi_cnt >= RP_MAX));

  p_ras_low_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_lo_cnt >= RAS_MAX));

  p_hit_keeps_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_accept |=> !ras_n);

  p_cbr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> ($past(cas_n) == 1'b0));

endmodule

// File: rtl/edo_datapath.sv
module edo_datapath #(
  parameter int unsigned ROW_W = 12,
  parameter int unsigned COL_W = 10,
  parameter int unsigned DQ_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]        req_wdata,
  input  logic                   bus_col,
  input  logic                   drive_dq,
  input  logic                   cap_now,
  input  logic [DQ_W-1:0]        dq_in,
  output logic [ROW_W-1:0]       req_row,
  output logic [ROW_W-1:0]       dram_addr,
  output logic [DQ_W-1:0]        dq_out,
  output logic                   dq_oe,
  output logic                   rsp_valid,
  output logic [DQ_W-1:0]        rsp_rdata
);
  localparam int unsigned AW = ROW_W + COL_W;

  function automatic logic [ROW_W-1:0] row_part(logic [AW-1:0] a);
    return a[AW-1:COL_W];
  endfunction

  function automatic logic [ROW_W-1:0] col_on_bus(logic [AW-1:0] a);
    return ROW_W'(a[COL_W-1:0]);
  endfunction

  logic [AW-1:0]   addr_q;
  logic [DQ_W-1:0] wdata_q;

  assign req_row   = row_part(req_addr);
  assign dram_addr = bus_col ? col_on_bus(addr_q) : row_part(addr_q);
  assign dq_out    = wdata_q;
  assign dq_oe     = drive_dq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      rsp_valid <= cap_now;
      if (cap_now) rsp_rdata <= dq_in;
    end
  end

  p_rsp_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl #(
  parameter int unsigned ROW_W        = 12,
  parameter int unsigned COL_W        = 10,
  parameter int unsigned DQ_W         = 4,
  parameter int unsigned T_RCD        = 3,
  parameter int unsigned T_CAS        = 2,
  parameter int unsigned T_CP         = 1,
  parameter int unsigned T_RP         = 4,
  parameter int unsigned T_RAS        = 6,
  parameter int unsigned T_CSR        = 1,
  parameter int unsigned REF_INTERVAL = 1560
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rsp_valid,
  output logic [DQ_W-1:0]        rsp_rdata,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [ROW_W-1:0]       dram_addr,
  output logic [DQ_W-1:0]        dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DQ_W-1:0]        dram_dq_in
);
  logic             ref_pend, ref_tick, ref_ack;
  logic             accept, bus_col, drive_dq, cap_now;
  logic [ROW_W-1:0] req_row;

  edo_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack),
    .ref_pend(ref_pend), .ref_tick(ref_tick)
  );

  edo_seq #(
    .ROW_W(ROW_W), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
    .T_RP(T_RP), .T_RAS(T_RAS), .T_CSR(T_CSR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_row(req_row), .ref_pend(ref_pend), .req_ready(req_ready),
    .accept(accept), .ref_ack(ref_ack), .ras_n(dram_ras_n),
    .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
    .bus_col(bus_col), .drive_dq(drive_dq), .cap_now(cap_now)
  );

  edo_datapath #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .bus_col(bus_col), .drive_dq(drive_dq),
    .cap_now(cap_now), .dq_in(dram_dq_in), .req_row(req_row),
    .dram_addr(dram_addr), .dq_out(dram_dq_out), .dq_oe(dram_dq_oe),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  p_no_bus_fight_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dram_dq_oe && !dram_oe_n));

  p_we_oe_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dram_we_n && !dram_oe_n));

endmodule

// File: tb/sim_edo_page_ctrl.sv
`timescale 1ns/1ps
module sim_edo_page_ctrl;
  localparam int T_RCD = 3, T_CAS = 2, T_CP = 1, T_RP = 4, T_RAS = 6, T_CSR = 1;
  localparam int REF_INTERVAL = 1560;
  localparam int SLACK = 32;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [21:0] req_addr = '0;
  logic [3:0] req_wdata = '0;
  logic req_ready, rsp_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [3:0] rsp_rdata, dq_out, dq_in;
  logic [11:0] dbus;

  always #5 clk = ~clk;

  edo_page_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(dbus),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  typedef struct { bit we; logic [21:0] a; logic [3:0] d; } item_t;
  item_t q_rsp[$];
  item_t q_adr[$];
  logic [3:0] ref_mem [int];
  logic [3:0] dram_mem [int];

  function automatic logic [3:0] rd_ref(int k);
    return ref_mem.exists(k) ? ref_mem[k] : 4'h0;
  endfunction
  function automatic logic [3:0] rd_dram(int k);
    return dram_mem.exists(k) ? dram_mem[k] : 4'h0;
  endfunction

  // scoreboard driver
  task automatic issue(input bit we, input logic [21:0] a, input logic [3:0] d);
    item_t it;
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    it.we = we; it.a = a; it.d = we ? d : rd_ref(int'(a));
    if (we) ref_mem[int'(a)] = d;
    q_rsp.push_back(it);
    q_adr.push_back(it);
  endtask

  task automatic go_idle(input int n);
    @(negedge clk); req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  // DRAM model, EDO read data
  logic m_pcas = 1, m_pras = 1, m_val = 0, m_pend = 0;
  logic [3:0] m_data = 0;
  logic [11:0] m_row = 0;
  assign dq_in = (m_val && !oe_n) ? m_data : ~m_data;

  always @(negedge clk) if (rst_n) begin
    if (ras_n && cas_n) begin m_val = 0; m_pend = 0; end
    if (m_pras && !ras_n && cas_n) m_row = dbus;
    if (m_pcas && !cas_n && !ras_n) begin
      item_t it;
      int k;
      k = int'({m_row, dbus[9:0]});
      chk(dbus[11:10] == 2'b00, "R1 column pad", int'(dbus[11:10]), 0);
      if (q_adr.size() == 0) chk(0, "R1 unexpected column strobe", 0, 1);
      else begin
        it = q_adr.pop_front();
        chk(k == int'(it.a), "R1 latched address", k, int'(it.a));
        chk(we_n == !it.we, "R7 write enable", int'(we_n), int'(!it.we));
        if (it.we) chk(dq_oe == 1'b1, "R7 data driven", int'(dq_oe), 1);
      end
      if (!we_n) dram_mem[k] = dq_out;
      else begin m_data = rd_dram(k); m_pend = 1; m_val = 0; end
    end else if (m_pend) begin m_val = 1; m_pend = 0; end
    m_pcas = cas_n; m_pras = ras_n;
  end

  // response monitor
  int n_rsp = 0;
  always @(negedge clk) if (rst_n && rsp_valid) begin
    item_t it;
    n_rsp++;
    if (q_rsp.size() == 0) chk(0, "R6 response without request", 1, 0);
    else begin
      it = q_rsp.pop_front();
      if (!it.we) chk(rsp_rdata == it.d, "R6 read data", int'(rsp_rdata), int'(it.d));
    end
  end

  // protocol monitor
  int ncyc = 0, hi = 1000, lo = 0, c_lo = 0, c_hi = 1000, fall_at = 0;
  int n_act = 0, n_ref = 0, last_ref = 0;
  bit p_ras = 1, p_cas = 1, first_cas = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(ras_n && cas_n && we_n && oe_n, "R10 strobes high in reset",
          int'({ras_n, cas_n, we_n, oe_n}), 15);
      chk(!dq_oe && !rsp_valid, "R10 bus and response idle", int'({dq_oe, rsp_valid}), 0);
    end else begin
      ncyc++;
      chk(!(!oe_n && (!we_n || dq_oe)), "R11 output enable exclusive",
          int'({oe_n, we_n, dq_oe}), 7);
      if (p_ras && !ras_n) begin
        chk(hi >= T_RP, "R3 precharge", hi, T_RP);
        fall_at = ncyc;
        if (!cas_n) begin
          chk(c_lo >= T_CSR, "R8 cas before ras", c_lo, T_CSR);
          chk(ncyc - last_ref <= REF_INTERVAL + SLACK, "R9 refresh gap",
              ncyc - last_ref, REF_INTERVAL + SLACK);
          last_ref = ncyc; n_ref++;
        end else begin n_act++; first_cas = 1; end
      end
      if (!p_ras && ras_n) chk(lo >= T_RAS, "R5 ras low time", lo, T_RAS);
      if (p_cas && !cas_n && !ras_n) begin
        if (first_cas) chk(ncyc - fall_at == T_RCD, "R4 ras to cas", ncyc - fall_at, T_RCD);
        else chk(c_hi >= T_CP, "R5 cas precharge", c_hi, T_CP);
        first_cas = 0;
      end
      if (!p_cas && cas_n) chk(c_lo >= T_CAS, "R5 cas low time", c_lo, T_CAS);
      if (ras_n) begin hi++; lo = 0; end else begin lo++; hi = 0; end
      if (cas_n) begin c_hi++; c_lo = 0; end else begin c_lo++; c_hi = 0; end
      p_ras = ras_n; p_cas = cas_n;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  int a0, r0, n_iss;
  initial begin
    n_iss = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ras_n && cas_n && !rsp_valid, "R10 after reset", int'({ras_n, cas_n, rsp_valid}), 6);

    // R2: page hits within one row
    a0 = n_act; r0 = n_ref;
    for (int i = 0; i < 8; i++) begin issue(1, {12'h3A5, 10'(i * 37)}, 4'(i + 3)); n_iss++; end
    for (int i = 0; i < 8; i++) begin issue(0, {12'h3A5, 10'(i * 37)}, 4'h0); n_iss++; end
    go_idle(20);
    chk(n_act - a0 <= 1 + (n_ref - r0), "R2 one activation per page", n_act - a0, 1);

    // R3/R1: row misses and aliasing of row vs column bits
    a0 = n_act; r0 = n_ref;
    issue(1, 22'h000001, 4'h5); issue(1, 22'h000401, 4'hA);
    issue(1, 22'h200001, 4'hC); issue(1, 22'h000201, 4'h6);
    issue(0, 22'h000001, 0); issue(0, 22'h000401, 0);
    issue(0, 22'h200001, 0); issue(0, 22'h000201, 0);
    n_iss += 8;
    go_idle(20);
    chk(n_act - a0 >= 7, "R3 activation per row change", n_act - a0, 7);

    // R6/R7: mixed read/write alternation across two rows
    for (int i = 0; i < 24; i++) begin
      issue(i[0], {(i[1] ? 12'hFFF : 12'h001), 10'(1023 - i)}, 4'(i ^ 9)); n_iss++;
    end
    go_idle(20);

    // R9: long same-row stream spanning refresh intervals
    a0 = n_act; r0 = n_ref;
    for (int i = 0; i < 320; i++) begin issue(1, {12'h155, 10'(i)}, 4'(i * 7)); n_iss++; end
    for (int i = 0; i < 320; i++) begin issue(0, {12'h155, 10'(i)}, 4'h0); n_iss++; end
    go_idle(20);
    chk(n_ref - r0 >= 1, "R9 refresh inside open-page stream", n_ref - r0, 1);
    chk(n_act - a0 <= 1 + (n_ref - r0), "R9 page reopened only after refresh",
        n_act - a0, 1 + (n_ref - r0));

    // R8: idle refresh cadence
    go_idle(4 * REF_INTERVAL);
    chk(n_ref >= ncyc / REF_INTERVAL - 1, "R8 refresh count", n_ref, ncyc / REF_INTERVAL - 1);
    chk(n_rsp == n_iss, "R6 response count", n_rsp, n_iss);
    chk(q_rsp.size() == 0, "R6 outstanding responses", q_rsp.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule